// File: doc/BRIEF.md
# Tape Record Parity Checker with Bias-Stepping Re-Read

This block checks the characters of one record read from a multi-track tape. Each character frame carries six information bits, one parity bit and one timing-channel bit. The block checks the parity of every frame. At the end of the record it checks the longitudinal parity of each information channel and compares the number of characters against an expected count.

After each pass over a record the block gives one result. A clean pass produces a single-cycle record-good pulse. With automatic retry enabled, a failing pass asks for the record to be read again, and the read-bias select moves from nominal to high, then to low. After the third failing pass the block raises a hard error flag and loads an error code word.

With automatic retry disabled, every failing pass loads the code word and raises the flag at once. In that mode the re-read request is never raised, so the decision to re-read is left to the controller.

Top module: `tape_frame_checker`

## Requirements
- R1: A frame is good when its six data bits (frame[5:0]) and its parity bit (frame[6]) together hold an odd number of ones. Any bad frame in a pass, including the closing check frame, makes that pass fail.
- R2: The frame presented with `rec_end` high is the longitudinal check frame. For each channel, the XOR of that channel over all data frames and the check frame must be zero. A nonzero result makes the pass fail.
- R3: Only frames taken with `rec_end` low are counted. The count must equal `exp_count`, which is sampled together with the check frame. A difference makes the pass fail.
- R4: A clean pass pulses `rec_good` for exactly one cycle. The pulse appears one clock after the edge that takes the check frame. The same edge clears `err_flag` and returns `bias_sel` to nominal (00).
- R5: With `AUTO_RETRY`=1, a failing pass that still has retries left pulses `reread_req` for one cycle, in the same cycle in which a pass would report. It also steps `bias_sel` to 01 (high) after the first failure and to 10 (low) after the second. `bias_sel` never takes the value 11.
- R6: With `AUTO_RETRY`=1, the third consecutive failing pass sets `err_flag` and loads `err_code` without a re-read request. It also returns `bias_sel` to 00.
- R7: `err_code` has the layout {`CODE_TAG` in [7:4] (default 4'hC), 0 in [3], count fault in [2], longitudinal fault in [1], frame parity fault in [0]}. It holds its value until the next load.
- R8: With `AUTO_RETRY`=0, every failing pass sets `err_flag` and loads `err_code`. In this mode `reread_req` stays low and `bias_sel` stays 00.
- R9: The timing-channel bit (frame[7]) has no effect on any result.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | A frame is present on `frame` this cycle |
| frame | input | 8 | {timing, parity, data[5:0]} |
| rec_end | input | 1 | The current frame is the longitudinal check frame |
| exp_count | input | CNT_W | Expected number of data frames, sampled with `rec_end` |
| err_flag | output | 1 | Hard failure is active |
| err_code | output | 8 | Failure code word |
| reread_req | output | 1 | One-cycle request to read the record again |
| bias_sel | output | 2 | Read bias: 00 nominal, 01 high, 10 low |
| rec_good | output | 1 | One-cycle pulse for a clean pass |

## Verification
The bench builds two copies of the block on the same stimulus, one with `AUTO_RETRY`=1 and one with `AUTO_RETRY`=0. All other parameters stay at their defaults, so `MAX_RETRY`=2 and `CODE_TAG`=4'hC. The automatic copy can therefore be driven through the full nominal, high and low bias sequence into a hard failure. The manual copy shows the same faults turning into an immediate code-word load with no re-read request. Each fault type (frame parity, longitudinal, count) is injected on its own, so every code-word bit is observed separately.

// File: rtl/tape_frame_checker.sv
module tape_frame_checker #(
  parameter int         DATA_W     = 6,
  parameter int         CNT_W      = 12,
  parameter int         MAX_RETRY  = 2,
  parameter bit         AUTO_RETRY = 1'b1,
  parameter logic [3:0] CODE_TAG   = 4'hC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic [DATA_W+1:0] frame,
  input  logic             rec_end,
  input  logic [CNT_W-1:0] exp_count,
  output logic             err_flag,
  output logic [7:0]       err_code,
  output logic             reread_req,
  output logic [1:0]       bias_sel,
  output logic             rec_good
);
  localparam int PASS_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  logic [DATA_W-1:0] lrc_acc;
  logic              par_bad_acc;
  logic [CNT_W-1:0]  char_cnt;
  logic              eval_q;
  logic [2:0]        cause_q;
  logic [PASS_W-1:0] pass_q;

  wire [DATA_W-1:0] data     = frame[DATA_W-1:0];
  wire              frame_ok = ^frame[DATA_W:0];
  wire [DATA_W-1:0] lrc_next = lrc_acc ^ data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrc_acc     <= '0;
      par_bad_acc <= 1'b0;
      char_cnt    <= '0;
      eval_q      <= 1'b0;
      cause_q     <= '0;
    end else begin
      eval_q <= 1'b0;
      if (frame_vld) begin
        if (rec_end) begin
          cause_q     <= {char_cnt != exp_count, |lrc_next, par_bad_acc | ~frame_ok};
          eval_q      <= 1'b1;
          lrc_acc     <= '0;
          par_bad_acc <= 1'b0;
          char_cnt    <= '0;
        end else begin
          lrc_acc     <= lrc_next;
          par_bad_acc <= par_bad_acc | ~frame_ok;
          char_cnt    <= char_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q     <= '0;
      rec_good   <= 1'b0;
      reread_req <= 1'b0;
      err_flag   <= 1'b0;
      err_code   <= '0;
    end else begin
      rec_good   <= 1'b0;
      reread_req <= 1'b0;
      if (eval_q) begin
        if (cause_q == 3'b000) begin
          rec_good <= 1'b1;
          err_flag <= 1'b0;
          pass_q   <= '0;
        end else if (AUTO_RETRY && (pass_q < PASS_W'(MAX_RETRY))) begin
          reread_req <= 1'b1;
          pass_q     <= pass_q + 1'b1;
        end else begin
          err_flag <= 1'b1;
          err_code <= {CODE_TAG, 1'b0, cause_q};
          pass_q   <= '0;
        end
      end
    end
  end

  assign bias_sel = (pass_q == '0) ? 2'b00 : (pass_q[0] ? 2'b01 : 2'b10);

endmodule

// File: rtl/tape_frame_checker_sva.sv
module tape_frame_checker_sva #(
  parameter bit         AUTO_RETRY = 1'b1,
  parameter logic [3:0] CODE_TAG   = 4'hC
) (
  input logic       clk,
  input logic       rst_n,
  input logic       err_flag,
  input logic [7:0] err_code,
  input logic       reread_req,
  input logic [1:0] bias_sel,
  input logic       rec_good
);
  // R4
  good_not_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_good && reread_req));

  // R4
  good_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_good |-> (!err_flag && bias_sel == 2'b00));

  // R5
  retry_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reread_req |-> (bias_sel != 2'b00));

  // R5
  bias_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bias_sel != 2'b11);

  // R6
  hard_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (!reread_req && bias_sel == 2'b00));

  // R7
  code_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (err_code[7:4] == CODE_TAG && !err_code[3] && err_code[2:0] != 3'b000));

  // R8
  manual_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_RETRY == 1'b0) |-> (!reread_req && bias_sel == 2'b00));
endmodule

bind tape_frame_checker tape_frame_checker_sva #(
  .AUTO_RETRY(AUTO_RETRY),
  .CODE_TAG  (CODE_TAG)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_flag  (err_flag),
  .err_code  (err_code),
  .reread_req(reread_req),
  .bias_sel  (bias_sel),
  .rec_good  (rec_good)
);

// File: tb/tape_frame_checker_test.sv
module tape_frame_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_vld = 1'b0;
  logic [7:0]  frame = '0;
  logic        rec_end = 1'b0;
  logic [11:0] exp_count = '0;

  logic       a_err, a_rr, a_good, m_err, m_rr, m_good;
  logic [7:0] a_code, m_code;
  logic [1:0] a_bias, m_bias;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tape_frame_checker #(.AUTO_RETRY(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
    .rec_end(rec_end), .exp_count(exp_count), .err_flag(a_err),
    .err_code(a_code), .reread_req(a_rr), .bias_sel(a_bias), .rec_good(a_good));

  tape_frame_checker #(.AUTO_RETRY(1'b0)) uut_man (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
    .rec_end(rec_end), .exp_count(exp_count), .err_flag(m_err),
    .err_code(m_code), .reread_req(m_rr), .bias_sel(m_bias), .rec_good(m_good));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 clean, 1 frame parity fault, 2 longitudinal fault, 3 count fault
  task automatic run_pass(input int n, input int seed, input int kind, input bit tlow);
    logic [5:0] lrc = '0;
    for (int i = 0; i < n; i++) begin
      logic [5:0] d;
      logic p;
      d = 6'(seed * 7 + i * 13 + 1);
      p = ~^d;
      if (kind == 1 && i == 1) p = ~p;
      frame = {~tlow, p, d};
      frame_vld = 1'b1;
      rec_end = 1'b0;
      lrc ^= d;
      @(negedge clk);
    end
    if (kind == 2) lrc ^= 6'h04;
    frame = {~tlow, ~^lrc, lrc};
    rec_end = 1'b1;
    exp_count = 12'(n + ((kind == 3) ? 1 : 0));
    @(negedge clk);
    frame_vld = 1'b0;
    rec_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 a_err", a_err, 0);  chk("R10 a_code", a_code, 0);
    chk("R10 a_rr", a_rr, 0);    chk("R10 a_bias", a_bias, 0);
    chk("R10 a_good", a_good, 0); chk("R10 m_err", m_err, 0);
    chk("R10 m_code", m_code, 0); chk("R10 m_good", m_good, 0);
  endtask

  task automatic t_clean;
    run_pass(5, 1, 0, 1'b0);
    chk("R4 a_good", a_good, 1); chk("R4 a_rr", a_rr, 0);
    chk("R4 a_bias", a_bias, 0); chk("R4 a_err", a_err, 0);
    chk("R4 m_good", m_good, 1);
    @(negedge clk);
    chk("R4 pulse width", a_good, 0);
  endtask

  task automatic t_parity_recover;
    run_pass(6, 2, 1, 1'b0);
    chk("R1 a_rr", a_rr, 1); chk("R1 a_good", a_good, 0);
    chk("R5 bias high", a_bias, 2'b01);
    chk("R8 m_err", m_err, 1); chk("R7 m_code parity", m_code, 8'hC1);
    chk("R8 m_rr", m_rr, 0);   chk("R8 m_bias", m_bias, 0);
    run_pass(6, 2, 0, 1'b0);
    chk("R4 retry good", a_good, 1); chk("R4 bias back", a_bias, 0);
    chk("R4 m_err cleared", m_err, 0); chk("R4 m_good", m_good, 1);
  endtask

  task automatic t_lrc_hard;
    run_pass(7, 3, 2, 1'b0);
    chk("R2 a_rr", a_rr, 1); chk("R5 bias high", a_bias, 2'b01);
    chk("R7 m_code lrc", m_code, 8'hC2);
    run_pass(7, 3, 2, 1'b0);
    chk("R5 a_rr second", a_rr, 1); chk("R5 bias low", a_bias, 2'b10);
    chk("R5 a_err still low", a_err, 0);
    run_pass(7, 3, 2, 1'b0);
    chk("R6 a_err", a_err, 1); chk("R6 a_rr", a_rr, 0);
    chk("R6 bias nominal", a_bias, 0); chk("R7 a_code lrc", a_code, 8'hC2);
    run_pass(3, 4, 0, 1'b0);
    chk("R4 err cleared", a_err, 0); chk("R4 good after hard", a_good, 1);
    chk("R7 code held", a_code, 8'hC2);
  endtask

  task automatic t_count;
    run_pass(4, 6, 3, 1'b0);
    chk("R3 a_rr", a_rr, 1); chk("R3 a_good", a_good, 0);
    chk("R7 m_code count", m_code, 8'hC4);
    run_pass(4, 6, 3, 1'b0);
    run_pass(4, 6, 3, 1'b0);
    chk("R6 a_err count", a_err, 1); chk("R7 a_code count", a_code, 8'hC4);
    run_pass(4, 6, 0, 1'b0);
    chk("R3 clean count", a_good, 1);
  endtask

  task automatic t_timing;
    run_pass(4, 5, 0, 1'b1);
    chk("R9 a_good", a_good, 1); chk("R9 a_rr", a_rr, 0);
    chk("R9 m_good", m_good, 1); chk("R9 m_err", m_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_parity_recover();
    t_lrc_hard();
    t_count();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule